// File: doc/BRIEF.md
# Direct-Mapped Line Cache with Write-Through

This block is a direct-mapped cache between a processor port and a slower main-memory port. The processor issues single 32-bit word reads and writes. Each cache line holds four words (128 bits). The cache checks the tag and valid bit of the one entry that the address indexes, picks the requested word out of the line, and stalls the processor while it fetches a missing line from memory.

Every write goes through to memory as a single word write. A write that misses first brings the whole line into the cache. It then merges the new word into that line and sends the same word to memory. A miss always fills the line and then replays the original request, which then completes as a hit. The processor must hold its request stable until the cache completes it.

The memory side has two channels, each with its own request/acknowledge pair. One reads a whole line at an aligned address. The other writes one word. The depth of the entry array is a parameter, so a simulation can use a small array while the default keeps 4096 entries.

Top module: `dmc_cache`

## Requirements
- R1: An address splits into byte offset bits 1..0, which are ignored, word offset bits 3..2, index bits (4+IDX_W-1)..4 and tag bits 31..(4+IDX_W). With the default IDX_W=12 the tag is bits 31..16 and there are 4096 entries.
- R2: Reset marks every entry invalid, so the first access to any line after reset misses and requests that line from memory.
- R3: A lookup hits only when the indexed entry is valid and its stored tag equals the address tag. An access to the same index with a different tag misses and replaces the line.
- R4: A read hit completes in the cycle it is presented (cpuReady high, cpuStall low) with no memory request. It returns line bits [32k+31:32k], where k is the word offset.
- R5: A read miss raises memRdReq with the line address (low 4 bits zero). It stores the returned 128-bit line, in which word k sits at bits [32k+31:32k], together with its tag and valid bit. The request then replays as a hit and returns the fetched word.
- R6: A write hit updates the addressed word in the cache and issues exactly one memory word write with the word-aligned address and the write data. It completes when that write is acknowledged.
- R7: A write miss first refills the whole line. It then merges the written word, keeps the other three words of the fetched line, and only after that issues a single memory word write.
- R8: cpuStall is high in every cycle in which a request is pending and not completing. It is low in the completing cycle and when no request is present.
- R9: Each memory request stays high until it is acknowledged, and a read request and a write request are never raised together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor request present |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Byte address of the word |
| cpuWdata | input | 32 | Write data |
| cpuReady | output | 1 | Request completes this cycle |
| cpuStall | output | 1 | Request pending, not completing |
| cpuRdata | output | 32 | Read data, valid with cpuReady on a read |
| memRdReq | output | 1 | Line read request |
| memRdAddr | output | ADDR_W | Line-aligned read address |
| memRdAck | input | 1 | Line read acknowledge, data valid |
| memRdData | input | 128 | Line read data |
| memWrReq | output | 1 | Word write request |
| memWrAddr | output | ADDR_W | Word-aligned write address |
| memWrData | output | 32 | Word write data |
| memWrAck | input | 1 | Word write acknowledge |

## Verification
The assertions check every cycle that memory requests are held until acknowledged. They also check that a line fill makes the held address hit on the next cycle, that a merged word reads back at once, that the memory write of a write miss begins only after the merge, and that a pending refill keeps the processor stalled. The bench's scenarios are the only way to show that data is right end to end. They sweep every word of every line of a small cache against a flat memory image, force index conflicts, and check both write paths. The bench also counts memory transactions, so it can tell a hit from a miss and confirm that a write miss orders the refill before the single word write.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef struct packed {
    logic fillLine;   // load line, tag and valid from memory
    logic writeWord;  // merge processor word into the indexed line
  } dmc_strobe_t;

  typedef enum logic [1:0] {
    ST_LOOKUP = 2'd0,
    ST_REFILL = 2'd1,
    ST_WRTHRU = 2'd2
  } dmc_state_t;
endpackage

// File: rtl/dmc_datapath.sv
module dmc_datapath
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 12,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dmc_strobe_t              strb,
  input  logic [ADDR_W-1:0]        cpuAddr,
  input  logic [WORD_W-1:0]        cpuWdata,
  input  logic [WORD_W*WORDS-1:0]  memRdData,
  output logic                     lookHit,
  output logic [WORD_W-1:0]        rdWord,
  output logic [ADDR_W-1:0]        lineAddr,
  output logic [ADDR_W-1:0]        wordAddr
);
  localparam int OFF_W   = $clog2(WORDS);
  localparam int BYTE_W  = $clog2(WORD_W / 8);
  localparam int LO_W    = OFF_W + BYTE_W;
  localparam int TAG_W   = ADDR_W - IDX_W - LO_W;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int LINE_W  = WORD_W * WORDS;

  logic [TAG_W-1:0] tagF;
  logic [IDX_W-1:0] idxF;
  logic [OFF_W-1:0] offF;
  logic [BYTE_W-1:0] unusedByte;

  assign tagF       = cpuAddr[ADDR_W-1 -: TAG_W];
  assign idxF       = cpuAddr[LO_W +: IDX_W];
  assign offF       = cpuAddr[BYTE_W +: OFF_W];
  assign unusedByte = cpuAddr[BYTE_W-1:0];

  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagQ  [ENTRIES];
  logic [LINE_W-1:0]  dataQ [ENTRIES];

  logic [LINE_W-1:0]  lineCur;
  logic [LINE_W-1:0]  mergedLine;
  logic [WORD_W-1:0]  wordSel [WORDS];

  assign lineCur = dataQ[idxF];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    assign wordSel[g] = lineCur[g*WORD_W +: WORD_W];
    assign mergedLine[g*WORD_W +: WORD_W] =
      (offF == OFF_W'(g)) ? cpuWdata : lineCur[g*WORD_W +: WORD_W];
  end

  assign rdWord   = wordSel[offF];
  assign lookHit  = validQ[idxF] && (tagQ[idxF] == tagF);
  assign lineAddr = {cpuAddr[ADDR_W-1:LO_W], {LO_W{1'b0}}};
  assign wordAddr = {cpuAddr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= '0;
    else if (strb.fillLine) validQ[idxF] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.fillLine) begin
      tagQ[idxF]  <= tagF;
      dataQ[idxF] <= memRdData;
    end else if (strb.writeWord) begin
      dataQ[idxF] <= mergedLine;
    end
  end

  // R5: a filled line hits for the held address on the next cycle
  p_fill_then_hit_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillLine |=> lookHit);

  // R6: a merged word is visible in the line on the next cycle
  p_merge_visible_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeWord |=> (rdWord == $past(cpuWdata)));
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuValid,
  input  logic        cpuWrite,
  input  logic        lookHit,
  input  logic        memRdAck,
  input  logic        memWrAck,
  output dmc_strobe_t strb,
  output logic        cpuReady,
  output logic        cpuStall,
  output logic        memRdReq,
  output logic        memWrReq
);
  dmc_state_t stateQ, stateD;

  always_comb begin
    stateD   = stateQ;
    strb     = '0;
    cpuReady = 1'b0;
    unique case (stateQ)
      ST_LOOKUP: begin
        if (cpuValid) begin
          if (!lookHit) begin
            stateD = ST_REFILL;
          end else if (cpuWrite) begin
            strb.writeWord = 1'b1;
            stateD         = ST_WRTHRU;
          end else begin
            cpuReady = 1'b1;
          end
        end
      end
      ST_REFILL: begin
        if (memRdAck) begin
          strb.fillLine = 1'b1;
          stateD        = ST_LOOKUP;
        end
      end
      ST_WRTHRU: begin
        if (memWrAck) begin
          cpuReady = 1'b1;
          stateD   = ST_LOOKUP;
        end
      end
      default: stateD = ST_LOOKUP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_LOOKUP;
    else       stateQ <= stateD;
  end

  assign memRdReq = (stateQ == ST_REFILL);
  assign memWrReq = (stateQ == ST_WRTHRU);
  assign cpuStall = cpuValid && !cpuReady;

  // R9: requests held until acknowledged
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && !memRdAck) |=> memRdReq);
  p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memWrReq && !memWrAck) |=> memWrReq);

  // R7: a memory write starts only right after a word merge
  p_wr_after_merge_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWrReq) |-> $past(strb.writeWord));

  // R8: a pending refill keeps the processor stalled
  p_stall_refill_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && memRdReq) |-> cpuStall);
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 12,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cpuValid,
  input  logic                    cpuWrite,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [WORD_W-1:0]       cpuWdata,
  output logic                    cpuReady,
  output logic                    cpuStall,
  output logic [WORD_W-1:0]       cpuRdata,
  output logic                    memRdReq,
  output logic [ADDR_W-1:0]       memRdAddr,
  input  logic                    memRdAck,
  input  logic [WORD_W*WORDS-1:0] memRdData,
  output logic                    memWrReq,
  output logic [ADDR_W-1:0]       memWrAddr,
  output logic [WORD_W-1:0]       memWrData,
  input  logic                    memWrAck
);
  dmc_strobe_t strb;
  logic        lookHit;

  dmc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuValid (cpuValid),
    .cpuWrite (cpuWrite),
    .lookHit  (lookHit),
    .memRdAck (memRdAck),
    .memWrAck (memWrAck),
    .strb     (strb),
    .cpuReady (cpuReady),
    .cpuStall (cpuStall),
    .memRdReq (memRdReq),
    .memWrReq (memWrReq)
  );

  dmc_datapath #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .WORD_W (WORD_W),
    .WORDS  (WORDS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cpuAddr   (cpuAddr),
    .cpuWdata  (cpuWdata),
    .memRdData (memRdData),
    .lookHit   (lookHit),
    .rdWord    (cpuRdata),
    .lineAddr  (memRdAddr),
    .wordAddr  (memWrAddr)
  );

  assign memWrData = cpuWdata;
endmodule

// File: tb/dmc_cache_tb.sv
module dmc_cache_tb_top;
  localparam int IDX_W   = 3;
  localparam int LINES   = 1 << IDX_W;
  localparam int TAG_SH  = 4 + IDX_W;
  localparam int LAT     = 2;

  logic         clk = 1'b0;
  logic         rstN;
  logic         cpuValid, cpuWrite;
  logic [31:0]  cpuAddr, cpuWdata;
  logic         cpuReady, cpuStall;
  logic [31:0]  cpuRdata;
  logic         memRdReq, memRdAck;
  logic [31:0]  memRdAddr;
  logic [127:0] memRdData;
  logic         memWrReq, memWrAck;
  logic [31:0]  memWrAddr, memWrData;

  always #2.5 clk = ~clk;

  dmc_cache #(.IDX_W(IDX_W)) dut_i (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuReady(cpuReady),
    .cpuStall(cpuStall), .cpuRdata(cpuRdata), .memRdReq(memRdReq),
    .memRdAddr(memRdAddr), .memRdAck(memRdAck), .memRdData(memRdData),
    .memWrReq(memWrReq), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .memWrAck(memWrAck)
  );

  int checks = 0;
  int errors = 0;

  // flat reference / main memory image, word index = addr[10:2]
  logic [31:0] mem [512];
  int rdCount = 0, wrCount = 0, overlap = 0, evStamp = 0;
  int rdStamp = 0, wrStamp = 0;
  int rdWait = 0, wrWait = 0;
  logic [31:0] lastRdAddr = '0, lastWrAddr = '0, lastWrData = '0;

  function automatic logic [31:0] initWord(int i);
    return 32'h1000_0000 + 32'(i) * 32'h0001_0203;
  endfunction

  function automatic logic [31:0] mkAddr(int tag, int idx, int off, int byteOff);
    return 32'((tag << TAG_SH) | (idx << 4) | (off << 2) | byteOff);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory responder, acts on falling edges
  initial begin
    for (int i = 0; i < 512; i++) mem[i] = initWord(i);
    memRdAck = 1'b0; memWrAck = 1'b0; memRdData = '0;
    forever begin
      @(negedge clk);
      if (memRdReq && memWrReq) overlap++;
      if (memRdAck) memRdAck = 1'b0;
      else if (memRdReq) begin
        rdWait++;
        if (rdWait == LAT) begin
          rdWait = 0;
          for (int k = 0; k < 4; k++)
            memRdData[k*32 +: 32] = mem[int'(memRdAddr[10:2]) + k];
          memRdAck = 1'b1; rdCount++; lastRdAddr = memRdAddr;
          evStamp++; rdStamp = evStamp;
        end
      end
      if (memWrAck) memWrAck = 1'b0;
      else if (memWrReq) begin
        wrWait++;
        if (wrWait == LAT) begin
          wrWait = 0;
          mem[memWrAddr[10:2]] = memWrData;
          memWrAck = 1'b1; wrCount++;
          lastWrAddr = memWrAddr; lastWrData = memWrData;
          evStamp++; wrStamp = evStamp;
        end
      end
    end
  end

  task automatic access(input bit w, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int waits, output bit stallOk);
    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = w; cpuAddr = a; cpuWdata = d;
    waits = 0; stallOk = 1'b1;
    #1;
    while (!cpuReady) begin
      if (!cpuStall) stallOk = 1'b0;
      @(negedge clk); #1;
      waits++;
    end
    if (cpuStall) stallOk = 1'b0;
    rd = cpuRdata;
    @(posedge clk); #1;
    cpuValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd, a;
    int waits, r0, w0;
    bit stallOk;
    cpuValid = 1'b0; cpuWrite = 1'b0; cpuAddr = '0; cpuWdata = '0;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(!cpuStall, "R8", "stall idle after reset", 32'(cpuStall), 0);
    chk(!memRdReq && !memWrReq, "R9", "no request after reset",
        32'({memRdReq, memWrReq}), 0);

    // sweep every word of every line (tag 0), varying the ignored byte offset
    for (int idx = 0; idx < LINES; idx++) begin
      for (int off = 0; off < 4; off++) begin
        a = mkAddr(0, idx, off, off);
        r0 = rdCount;
        access(1'b0, a, '0, rd, waits, stallOk);
        chk(rd == mem[a[10:2]], "R4", "read data", rd, mem[a[10:2]]);
        if (off == 0) begin
          chk(rdCount == r0 + 1, "R2", "first access misses", 32'(rdCount - r0), 1);
          chk(lastRdAddr == mkAddr(0, idx, 0, 0), "R5", "line address",
              lastRdAddr, mkAddr(0, idx, 0, 0));
          chk(stallOk && waits > 0, "R8", "stall during refill", 32'(waits), 1);
        end else begin
          chk(rdCount == r0 && waits == 0, "R4", "hit, no memory traffic",
              32'(waits), 0);
          chk(rd == mem[a[10:2]], "R1", "byte offset ignored", rd, mem[a[10:2]]);
        end
      end
    end

    // conflict on index 0: other tag misses, then original tag misses again
    r0 = rdCount;
    access(1'b0, mkAddr(1, 0, 2, 0), '0, rd, waits, stallOk);
    chk(rdCount == r0 + 1, "R3", "tag mismatch misses", 32'(rdCount - r0), 1);
    chk(rd == mem[mkAddr(1, 0, 2, 0) >> 2], "R5", "refilled word", rd,
        mem[mkAddr(1, 0, 2, 0) >> 2]);
    r0 = rdCount;
    access(1'b0, mkAddr(0, 0, 1, 0), '0, rd, waits, stallOk);
    chk(rdCount == r0 + 1, "R3", "evicted line misses", 32'(rdCount - r0), 1);
    chk(rd == initWord(1), "R5", "data after re-fill", rd, initWord(1));

    // write hit
    a = mkAddr(0, 2, 1, 0);
    r0 = rdCount; w0 = wrCount;
    access(1'b1, a, 32'hDEAD_BEEF, rd, waits, stallOk);
    chk(rdCount == r0, "R6", "write hit no refill", 32'(rdCount - r0), 0);
    chk(wrCount == w0 + 1, "R6", "one memory write", 32'(wrCount - w0), 1);
    chk(lastWrAddr == a, "R6", "write address", lastWrAddr, a);
    chk(lastWrData == 32'hDEAD_BEEF, "R6", "write data", lastWrData, 32'hDEAD_BEEF);
    chk(stallOk, "R8", "stall during write-through", 32'(stallOk), 1);
    access(1'b0, a | 32'd3, '0, rd, waits, stallOk);
    chk(waits == 0 && rd == 32'hDEAD_BEEF, "R6", "read back written word",
        rd, 32'hDEAD_BEEF);

    // write miss with allocation
    a = mkAddr(2, 5, 3, 0);
    r0 = rdCount; w0 = wrCount;
    access(1'b1, a, 32'h1234_5678, rd, waits, stallOk);
    chk(rdCount == r0 + 1, "R7", "write miss refills", 32'(rdCount - r0), 1);
    chk(wrCount == w0 + 1, "R7", "single word write", 32'(wrCount - w0), 1);
    chk(rdStamp < wrStamp, "R7", "refill before write", 32'(rdStamp), 32'(wrStamp));
    chk(lastWrAddr == a && lastWrData == 32'h1234_5678, "R7", "write contents",
        lastWrData, 32'h1234_5678);
    for (int off = 0; off < 3; off++) begin
      r0 = rdCount;
      access(1'b0, mkAddr(2, 5, off, 0), '0, rd, waits, stallOk);
      chk(rdCount == r0 && rd == initWord((mkAddr(2, 5, off, 0) >> 2)),
          "R7", "untouched fetched word", rd, initWord(mkAddr(2, 5, off, 0) >> 2));
    end
    access(1'b0, a, '0, rd, waits, stallOk);
    chk(waits == 0 && rd == 32'h1234_5678, "R7", "merged word", rd, 32'h1234_5678);

    @(negedge clk); #1;
    chk(!cpuStall, "R8", "stall low with no request", 32'(cpuStall), 0);
    chk(overlap == 0, "R9", "requests never overlap", 32'(overlap), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule